// File: doc/BRIEF.md
# Gated DAC Register Bank

This block holds the code words for eight digital-to-analog converter channels and decides when each stored code becomes visible on the converter-facing outputs. It has two register windows. A 32-bit control window holds a gating word and an interrupt control word. A 16-bit data window holds the eight channel code registers and a digital output latch that shares its offset with a digital input port.

Two bits of the gating word decide what the outputs show. An enable bit, when clear, grounds every channel. A hold bit, when set, freezes the outputs while new codes are stored in the background. A write to the gating word that leaves the bank enabled and not held reloads all eight outputs from the stored codes in one cycle. Each output register has a one-cycle load strobe, so the converter side knows when to sample.

Reads on both windows are combinational from the current state. Writes take effect at the clock edge on which they are presented.

Top module: `gated_dac_bank`

## Requirements
- R1: After reset, every stored code and every channel output is 0x3FFF. The gating word reads 0x0600_06C0, the interrupt word reads 0x300, the digital output is 0, and no load strobe is high.
- R2: A write at data offset 0x20+2k stores the code for channel k, and reads at that offset return it. When hold (gating bit 23) is 0 and enable (gating bit 26) is 1, channel k's output takes the written value on the next cycle, and only strobe k pulses.
- R3: A gating write with bit 26 at 0 drives all eight outputs to code 0 on the next cycle and pulses every strobe. While the bank is disabled, code writes are stored but outputs stay 0 and no strobe pulses.
- R4: A gating write changes only bits 23 and 26. Every other bit of the gating word always reads as the fixed pattern 0x0200_06C0.
- R5: A gating write that leaves hold at 0 and enable at 1 reloads all eight outputs from the stored codes on the next cycle and pulses every strobe.
- R6: While hold is 1 and enable is 1, code writes are stored, but no output changes and no strobe pulses. The gating write that clears hold reloads every output.
- R7: The interrupt word at control offset 0x4C keeps only the low 11 bits of a write, always has 0x300 ORed in, and reads 0 in bits 31:11.
- R8: A write at data offset 0x10 sets the digital output latch. A read at 0x10 returns the digital input port.
- R9: A strobe pulses for exactly the one cycle after its output register is loaded. In cycles with no load it stays low, and the output holds its value.
- R10: Reads at unmapped offsets return 0 in both windows. Writes to unmapped offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control window write strobe |
| cfg_addr | input | ADDR_W | Control window byte offset |
| cfg_wdata | input | 32 | Control window write data |
| cfg_rdata | output | 32 | Control window read data |
| reg_we | input | 1 | Data window write strobe |
| reg_addr | input | ADDR_W | Data window byte offset |
| reg_wdata | input | CODE_W | Data window write data |
| reg_rdata | output | CODE_W | Data window read data |
| dig_in | input | CODE_W | Digital input port |
| dig_out | output | CODE_W | Digital output latch |
| dac_out | output | NCH*CODE_W | Channel outputs, channel k in bits k*CODE_W upward |
| dac_upd | output | NCH | Per-channel output load strobe |

## Verification
The channel outputs are exercised with code writes in each of the three gating states: live, held and disabled. Comparing these cases separates immediate update, deferred update and grounding. Gating writes are tried with every hold and enable combination, including all-ones and all-zeros data words. These show both the write mask and the difference between a reload and a grounding. A scoreboard pairs each strobe with the expected channel and value, so a stray or missing strobe is detected as well as a wrong code. The interrupt word, the digital port and unmapped offsets are checked through readback.

// File: rtl/gdac_pkg.sv
package gdac_pkg;

  localparam int OFS_IRQ   = 'h4C;
  localparam int OFS_CTL   = 'h54;
  localparam int OFS_DIG   = 'h10;
  localparam int OFS_CODE0 = 'h20;

  localparam int HOLD_BIT = 23;
  localparam int EN_BIT   = 26;

  localparam logic [31:0] CTL_WMASK = (32'h1 << HOLD_BIT) | (32'h1 << EN_BIT);
  localparam logic [31:0] CTL_FIXED = 32'h0200_06C0;
  localparam logic [31:0] CTL_RST   = CTL_FIXED | (32'h1 << EN_BIT);
  localparam logic [31:0] IRQ_WMASK = 32'h0000_07FF;
  localparam logic [31:0] IRQ_FORCE = 32'h0000_0300;

  typedef enum logic [1:0] {
    LD_NONE,
    LD_WRITE,
    LD_STORED,
    LD_GROUND
  } load_e;

  function automatic logic [31:0] ctl_merge(input logic [31:0] w);
    return (w & CTL_WMASK) | CTL_FIXED;
  endfunction

  function automatic logic [31:0] irq_merge(input logic [31:0] w);
    return (w & IRQ_WMASK) | IRQ_FORCE;
  endfunction

  function automatic int code_offset(input int ch);
    return OFS_CODE0 + 2 * ch;
  endfunction

endpackage

// File: rtl/gdac_ctl.sv
module gdac_ctl
  import gdac_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              hold_o,
  output logic              en_o,
  output logic              ctl_wr_o,
  output logic              nxt_hold_o,
  output logic              nxt_en_o
);

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(OFS_IRQ);

  logic [31:0] ctl_q;
  logic [31:0] irq_q;
  logic [31:0] ctl_new;
  logic        hit_ctl;
  logic        hit_irq;

  assign hit_ctl = cfg_we && (cfg_addr == A_CTL);
  assign hit_irq = cfg_we && (cfg_addr == A_IRQ);
  assign ctl_new = ctl_merge(cfg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      irq_q <= IRQ_FORCE;
    end else begin
      if (hit_ctl) ctl_q <= ctl_new;
      if (hit_irq) irq_q <= irq_merge(cfg_wdata);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_CTL)      cfg_rdata = ctl_q;
    else if (cfg_addr == A_IRQ) cfg_rdata = irq_q;
  end

  assign hold_o     = ctl_q[HOLD_BIT];
  assign en_o       = ctl_q[EN_BIT];
  assign ctl_wr_o   = hit_ctl;
  assign nxt_hold_o = ctl_new[HOLD_BIT];
  assign nxt_en_o   = ctl_new[EN_BIT];

  // R4: only a write at the gating offset may alter the gating word
  a_r4_ctl_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ctl |=> $stable(ctl_q));

  // R7: interrupt word moves only on its own offset
  a_r7_irq_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_irq |=> $stable(irq_q));

  // R7: the forced bits never read low
  a_r7_irq_forced: assert property (@(posedge clk) disable iff (!rst_n)
    hit_irq |=> irq_q[9:8] == 2'b11);

endmodule

// File: rtl/gdac_chan.sv
module gdac_chan
  import gdac_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter logic [CODE_W-1:0] CODE_RST = 16'h3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              live_i,
  input  logic              reload_i,
  input  logic              ground_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] out_o,
  output logic              upd_o
);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nxt;
  logic [CODE_W-1:0] out_q;
  logic              upd_q;
  load_e             sel;

  assign code_nxt = wr_en ? wr_data : code_q;

  always_comb begin
    if (ground_i)            sel = LD_GROUND;
    else if (reload_i)       sel = LD_STORED;
    else if (wr_en && live_i) sel = LD_WRITE;
    else                     sel = LD_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= CODE_RST;
      out_q  <= CODE_RST;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_nxt;
      upd_q  <= (sel != LD_NONE);
      case (sel)
        LD_GROUND: out_q <= '0;
        LD_STORED: out_q <= code_nxt;
        LD_WRITE:  out_q <= wr_data;
        default:   out_q <= out_q;
      endcase
    end
  end

  assign code_o = code_q;
  assign out_o  = out_q;
  assign upd_o  = upd_q;

  // R2: a live write is visible next cycle with a strobe
  a_r2_live_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && live_i && !reload_i && !ground_i) |=> (out_o == $past(wr_data)) && upd_o);

  // R3: grounding forces code zero
  a_r3_ground_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ground_i |=> (out_o == '0) && upd_o);

  // R5: reload copies the stored code
  a_r5_reload_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !ground_i) |=> (out_o == code_o) && upd_o);

  // R9: no load means no strobe and no movement
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && live_i) && !reload_i && !ground_i) |=> !upd_o && $stable(out_o));

endmodule

// File: rtl/gated_dac_bank.sv
module gated_dac_bank
  import gdac_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CODE_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [CODE_W-1:0]     reg_wdata,
  output logic [CODE_W-1:0]     reg_rdata,
  input  logic [CODE_W-1:0]     dig_in,
  output logic [CODE_W-1:0]     dig_out,
  output logic [NCH*CODE_W-1:0] dac_out,
  output logic [NCH-1:0]        dac_upd
);

  localparam logic [ADDR_W-1:0] A_DIG    = ADDR_W'(OFS_DIG);
  localparam logic [CODE_W-1:0] CODE_DEF = CODE_W'(16'h3FFF);

  logic hold, en, ctl_wr, nxt_hold, nxt_en;
  logic live, reload, ground;
  logic [CODE_W-1:0] dig_q;
  logic [CODE_W-1:0] code_vec [NCH];
  logic [NCH-1:0]    code_hit;

  gdac_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .hold_o     (hold),
    .en_o       (en),
    .ctl_wr_o   (ctl_wr),
    .nxt_hold_o (nxt_hold),
    .nxt_en_o   (nxt_en)
  );

  assign live   = !hold && en;
  assign reload = ctl_wr && nxt_en && !nxt_hold;
  assign ground = ctl_wr && !nxt_en;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(code_offset(g));
    assign code_hit[g] = reg_we && (reg_addr == A_CODE);

    gdac_chan #(.CODE_W(CODE_W), .CODE_RST(CODE_DEF)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (code_hit[g]),
      .wr_data  (reg_wdata),
      .live_i   (live),
      .reload_i (reload),
      .ground_i (ground),
      .code_o   (code_vec[g]),
      .out_o    (dac_out[g*CODE_W +: CODE_W]),
      .upd_o    (dac_upd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          dig_q <= '0;
    else if (reg_we && reg_addr == A_DIG) dig_q <= reg_wdata;
  end
  assign dig_out = dig_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_DIG) reg_rdata = dig_in;
    for (int k = 0; k < NCH; k++) begin
      if (reg_addr == ADDR_W'(code_offset(k))) reg_rdata = code_vec[k];
    end
  end

  // R3: a disabled bank shows code zero on every channel
  a_r3_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> dac_out == '0);

  // R6: held outputs do not move without a gating write
  a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && en && !ctl_wr) |=> $stable(dac_out) && (dac_upd == '0));

  // R5: a reload pulses every strobe together
  a_r5_all_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> &dac_upd);

endmodule

// File: tb/test_gated_dac_bank.sv
module test_gated_dac_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] dig_in = 16'h00FF;
  logic [15:0] dig_out;
  logic [NCH*CW-1:0] dac_out;
  logic [NCH-1:0]    dac_upd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_dac_bank i_gated_dac_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dig_in(dig_in), .dig_out(dig_out), .dac_out(dac_out), .dac_upd(dac_upd)
  );

  typedef struct { int ch; logic [15:0] val; } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_code [NCH];
  logic m_hold = 1'b0;
  logic m_en   = 1'b1;
  bit   done   = 1'b0;

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endfunction

  // monitor: every strobe must match the oldest expected load (R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < NCH; k++) begin
        if (dac_upd[k]) begin
          if (q.size() == 0) begin
            check("R9 unexpected strobe channel", k, 32'hFFFF_FFFF);
          end else begin
            exp_t e;
            e = q.pop_front();
            check("R9 strobe channel order", k, e.ch);
            check("R2/R3/R5 loaded value", dac_out[k*CW +: CW], e.val);
          end
        end
      end
    end
  end

  task automatic wr_code(int k, logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'(32 + 2*k); reg_wdata = v;
    m_code[k] = v;
    if (!m_hold && m_en) q.push_back('{k, v});
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_ctl(logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h54; cfg_wdata = v;
    m_hold = v[23]; m_en = v[26];
    for (int k = 0; k < NCH; k++) begin
      if (!m_en)        q.push_back('{k, 16'h0});
      else if (!m_hold) q.push_back('{k, m_code[k]});
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_cfg(logic [7:0] a, logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_cfg(string tag, logic [7:0] a, logic [31:0] exp);
    cfg_addr = a; #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic rd_reg(string tag, logic [7:0] a, logic [15:0] exp);
    reg_addr = a; #1;
    check(tag, {16'h0, reg_rdata}, {16'h0, exp});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCH; k++) m_code[k] = 16'h3FFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_cfg("R1 gating word", 8'h54, 32'h0600_06C0);
    rd_cfg("R1 interrupt word", 8'h4C, 32'h300);
    for (int k = 0; k < NCH; k++) begin
      rd_reg("R1 stored code", 8'(32 + 2*k), 16'h3FFF);
      check("R1 output", dac_out[k*CW +: CW], 16'h3FFF);
    end
    check("R1 digital out", dig_out, 0);
    check("R1 strobes", dac_upd, 0);

    // R2 live writes
    wr_code(3, 16'h1234);
    wr_code(0, 16'h0001);
    wr_code(7, 16'hFFFF);
    rd_reg("R2 readback ch3", 8'h26, 16'h1234);
    rd_reg("R2 readback ch7", 8'h2E, 16'hFFFF);
    check("R2 untouched ch5", dac_out[5*CW +: CW], 16'h3FFF);

    // R8 digital port
    wr_reg(8'h10, 16'h00A5);
    check("R8 digital out", dig_out, 16'h00A5);
    rd_reg("R8 digital in default", 8'h10, 16'h00FF);
    dig_in = 16'h005A;
    rd_reg("R8 digital in", 8'h10, 16'h005A);

    // R7 interrupt word
    wr_cfg(8'h4C, 32'hFFFF_FFFF);
    rd_cfg("R7 interrupt mask", 8'h4C, 32'h7FF);
    wr_cfg(8'h4C, 32'h0);
    rd_cfg("R7 interrupt force", 8'h4C, 32'h300);

    // R4 mask, entering hold
    wr_ctl(32'hFFFF_FFFF);
    rd_cfg("R4 all-ones write", 8'h54, 32'h0680_06C0);
    // R3 disable
    wr_ctl(32'h0);
    rd_cfg("R4 all-zeros write", 8'h54, 32'h0200_06C0);
    wr_code(2, 16'h2222);
    rd_reg("R3 stored while disabled", 8'h24, 16'h2222);
    check("R3 output stays ground", dac_out[2*CW +: CW], 0);

    // R6 hold with enable
    wr_ctl(32'h0480_0000);
    wr_code(5, 16'h5555);
    check("R6 held output ch5", dac_out[5*CW +: CW], 0);
    check("R6 no strobe while held", dac_upd, 0);
    wr_ctl(32'h0400_0000);   // R5 release reloads all
    check("R5 reload ch5", dac_out[5*CW +: CW], 16'h5555);
    check("R5 reload ch2", dac_out[2*CW +: CW], 16'h2222);

    // R10 unmapped accesses
    wr_reg(8'h30, 16'hBEEF);
    wr_cfg(8'h00, 32'hFFFF_FFFF);
    rd_reg("R10 unmapped data read", 8'h30, 16'h0);
    rd_cfg("R10 unmapped control read", 8'h00, 32'h0);
    rd_cfg("R10 gating unchanged", 8'h54, 32'h0600_06C0);
    check("R10 output unchanged", dac_out[3*CW +: CW], 16'h1234);

    // R9 idle: no strobes
    repeat (5) @(negedge clk);
    check("R9 idle strobes", dac_upd, 0);
    check("R9 scoreboard drained", q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule